// File: doc/BRIEF.md
# Cascaded Power-Domain Sequencer

This block switches a set of power domains on or off one rank at a time. Every domain carries two programmable rank fields, one for turning on and one for turning off. A sequence visits the ranks from 0 upward. At each rank it raises a switch request to every participating domain of that rank, all at once. It moves to the next rank only after all of those domains have acknowledged. A domain takes part when its bit is set in the latched target vector, its rank for the current direction is legal (0 to 7), and its present mode differs from the direction being applied.

A sequence is started by an 8-bit software command code (turn-on or turn-off, with a software mode vector for each) or by any enabled hardware wake event (always turn-on, with the hardware mode vector). Each rank step has a programmable acknowledgment deadline. If the deadline is missed, the sequence aborts. It then raises a failure pulse that names the trigger type, and keeps only the mode changes that were acknowledged. A normal finish gives a one-cycle done pulse. The block also reports a 2-bit sequence phase, the set of hardware events that started the last hardware sequence, and whether the last trigger came from hardware.

Top module: `pd_cascade_seq`

## Requirements
- R1: After reset, cur_mode is 9'b000000011 (domains 0 and 1 on, all others off). seq_state is 0, dom_req is 0, and no done or fail pulse is present.
- R2: In idle, sw_kick = 8'hA0 starts a turn-on sequence toward sw_on_mode, and sw_kick = 8'h50 starts a turn-off sequence toward sw_off_mode. Any other code, 8'h00 included, is ignored. A software start clears evt_rec and clears trig_hw.
- R3: In idle, a cycle in which (hw_evt & hw_evt_en) is nonzero starts a turn-on sequence toward hw_on_mode. It sets trig_hw and loads evt_rec with those enabled fired bits. A fired event whose enable bit is clear is ignored. If a hardware start and a valid software code arrive in the same cycle, the hardware start wins.
- R4: Domains are requested in ascending rank order. The rank of domain i sits at bits [5i+4:5i] of on_rank or off_rank, chosen by direction. Domains of equal rank are requested in the same cycle. A higher rank is requested only after every domain of the lower rank has acknowledged. dom_on shows the direction (1 = on).
- R5: A domain whose rank field for the active direction is greater than 7 gets no request, and its mode bit is left unchanged.
- R6: A domain whose target bit is 0, or whose mode already equals the direction, gets no request and needs no acknowledgment.
- R7: A rank step fails unless every requested domain acknowledges within tmo_thd+1 cycles of its request. An acknowledgment that arrives in the last allowed cycle still counts. On failure, all requests drop. The block gives a one-cycle sw_fail pulse for a software trigger or a hw_fail pulse for a hardware trigger, and then returns to idle.
- R8: After a failure, cur_mode holds the changes of every domain that acknowledged before the deadline, and no others. Ranks above the failing rank are never requested.
- R9: A sequence that completes every rank gives exactly one seq_done pulse. cur_mode then equals the start mode with each participating domain set to the direction.
- R10: Triggers that arrive while a sequence runs are ignored, and they have no effect after the sequence ends.
- R11: seq_state reads 0 in idle, 1 while choosing a rank, 2 while waiting for acknowledgments, and 3 in the done or fail cycle. dom_req is nonzero only when seq_state is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_kick | input | 8 | Software command code (8'hA0 on, 8'h50 off) |
| hw_evt | input | 8 | Hardware wake event pulses |
| hw_evt_en | input | 8 | Per-event enable |
| sw_on_mode | input | 9 | Domains to turn on by software |
| sw_off_mode | input | 9 | Domains to turn off by software |
| hw_on_mode | input | 9 | Domains to turn on by hardware event |
| on_rank | input | 45 | Five-bit turn-on rank per domain |
| off_rank | input | 45 | Five-bit turn-off rank per domain |
| tmo_thd | input | 16 | Step acknowledgment deadline |
| dom_ack | input | 9 | Per-domain switch acknowledgment |
| dom_req | output | 9 | Per-domain switch request |
| dom_on | output | 1 | Direction of the active requests |
| seq_done | output | 1 | Sequence complete pulse |
| sw_fail | output | 1 | Software-started sequence failed |
| hw_fail | output | 1 | Hardware-started sequence failed |
| cur_mode | output | 9 | Present on/off state per domain |
| seq_state | output | 2 | Sequence phase code |
| evt_rec | output | 8 | Enabled events that started the last hardware sequence |
| trig_hw | output | 1 | Last trigger was hardware |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a hardware wake and a valid software code. The bench drives both on the same edge and judges the result by trig_hw, evt_rec and which mode vector ends up applied. The second pair is an acknowledgment and the step deadline. The bench sets the responder delay to exactly tmo_thd+1 and then to tmo_thd+2 cycles, and expects success in the first case and failure in the second. A sweep of pseudo-random rank, target and delay settings checks the request order, the final mode vector and the outcome against an arithmetic model.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_STEP,
    S_WAIT,
    S_DONE,
    S_FAIL
  } seq_st_e;

  localparam logic [7:0] KICK_ON  = 8'hA0;
  localparam logic [7:0] KICK_OFF = 8'h50;

  // a domain belongs to the step when its rank is legal and equals the step
  function automatic logic rank_selects(int rank, int step, int max_rank);
    return (rank <= max_rank) && (rank == step);
  endfunction

  // external phase code
  function automatic logic [1:0] phase_code(seq_st_e st);
    case (st)
      S_IDLE:  return 2'd0;
      S_STEP:  return 2'd1;
      S_WAIT:  return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/pds_rank_match.sv
module pds_rank_match #(
  parameter int N_DOM    = 9,
  parameter int RANK_W   = 5,
  parameter int MAX_RANK = 7,
  parameter int STEP_W   = 3
) (
  input  logic [N_DOM*RANK_W-1:0] on_rank,
  input  logic [N_DOM*RANK_W-1:0] off_rank,
  input  logic                    dir_on,
  input  logic [N_DOM-1:0]        tgt,
  input  logic [N_DOM-1:0]        mode,
  input  logic [STEP_W-1:0]       step,
  output logic [N_DOM-1:0]        hit
);
  import pds_pkg::*;

  for (genvar i = 0; i < N_DOM; i++) begin : g_dom
    logic [RANK_W-1:0] rk;
    assign rk = dir_on ? on_rank[i*RANK_W +: RANK_W] : off_rank[i*RANK_W +: RANK_W];
    assign hit[i] = tgt[i] && (mode[i] != dir_on) &&
                    rank_selects(int'(rk), int'(step), MAX_RANK);
  end

endmodule

// File: rtl/pds_step_timer.sv
module pds_step_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] thd,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == thd);

endmodule

// File: rtl/pd_cascade_seq.sv
module pd_cascade_seq #(
  parameter int N_DOM    = 9,
  parameter int N_EVT    = 8,
  parameter int RANK_W   = 5,
  parameter int MAX_RANK = 7,
  parameter int TMO_W    = 16,
  parameter logic [N_DOM-1:0] RST_MODE = 9'b000000011
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              sw_kick,
  input  logic [N_EVT-1:0]        hw_evt,
  input  logic [N_EVT-1:0]        hw_evt_en,
  input  logic [N_DOM-1:0]        sw_on_mode,
  input  logic [N_DOM-1:0]        sw_off_mode,
  input  logic [N_DOM-1:0]        hw_on_mode,
  input  logic [N_DOM*RANK_W-1:0] on_rank,
  input  logic [N_DOM*RANK_W-1:0] off_rank,
  input  logic [TMO_W-1:0]        tmo_thd,
  input  logic [N_DOM-1:0]        dom_ack,
  output logic [N_DOM-1:0]        dom_req,
  output logic                    dom_on,
  output logic                    seq_done,
  output logic                    sw_fail,
  output logic                    hw_fail,
  output logic [N_DOM-1:0]        cur_mode,
  output logic [1:0]              seq_state,
  output logic [N_EVT-1:0]        evt_rec,
  output logic                    trig_hw
);
  import pds_pkg::*;

  localparam int STEP_W = $clog2(MAX_RANK + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(MAX_RANK);

  seq_st_e           st;
  logic [STEP_W-1:0] cur_rank;
  logic              dir_q;
  logic [N_DOM-1:0]  tgt_q, req_q, mode_q;
  logic [N_EVT-1:0]  evt_q;
  logic              trig_hw_q;

  // named internal events
  logic [N_EVT-1:0] hw_fire;
  logic             start_hw, start_sw_on, start_sw_off;
  logic [N_DOM-1:0] rank_hits, pending, step_acked;
  logic             last_rank, step_expired;

  assign hw_fire      = hw_evt & hw_evt_en;
  assign start_hw     = (st == S_IDLE) && (|hw_fire);
  assign start_sw_on  = (st == S_IDLE) && !start_hw && (sw_kick == KICK_ON);
  assign start_sw_off = (st == S_IDLE) && !start_hw && (sw_kick == KICK_OFF);
  assign pending      = req_q & ~dom_ack;
  assign step_acked   = req_q & dom_ack;
  assign last_rank    = (cur_rank == LAST_STEP);

  pds_rank_match #(
    .N_DOM(N_DOM), .RANK_W(RANK_W), .MAX_RANK(MAX_RANK), .STEP_W(STEP_W)
  ) u_match (
    .on_rank (on_rank),
    .off_rank(off_rank),
    .dir_on  (dir_q),
    .tgt     (tgt_q),
    .mode    (mode_q),
    .step    (cur_rank),
    .hit     (rank_hits)
  );

  pds_step_timer #(.TMO_W(TMO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (st == S_STEP),
    .run    ((st == S_WAIT) && (|pending)),
    .thd    (tmo_thd),
    .expired(step_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_rank  <= '0;
      dir_q     <= 1'b0;
      tgt_q     <= '0;
      req_q     <= '0;
      mode_q    <= RST_MODE;
      evt_q     <= '0;
      trig_hw_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_hw) begin
            tgt_q <= hw_on_mode; dir_q <= 1'b1;
            evt_q <= hw_fire;    trig_hw_q <= 1'b1;
            cur_rank <= '0;      st <= S_STEP;
          end else if (start_sw_on || start_sw_off) begin
            tgt_q <= start_sw_on ? sw_on_mode : sw_off_mode;
            dir_q <= start_sw_on;
            evt_q <= '0;         trig_hw_q <= 1'b0;
            cur_rank <= '0;      st <= S_STEP;
          end
        end
        S_STEP: begin
          if (|rank_hits) begin
            req_q <= rank_hits;
            st    <= S_WAIT;
          end else if (last_rank) begin
            st <= S_DONE;
          end else begin
            cur_rank <= cur_rank + 1'b1;
          end
        end
        S_WAIT: begin
          mode_q <= dir_q ? (mode_q | step_acked) : (mode_q & ~step_acked);
          req_q  <= pending;
          if (pending == '0) begin
            if (last_rank) st <= S_DONE;
            else begin
              cur_rank <= cur_rank + 1'b1;
              st       <= S_STEP;
            end
          end else if (step_expired) begin
            req_q <= '0;
            st    <= S_FAIL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dom_req   = req_q;
  assign dom_on    = dir_q;
  assign seq_done  = (st == S_DONE);
  assign sw_fail   = (st == S_FAIL) && !trig_hw_q;
  assign hw_fail   = (st == S_FAIL) && trig_hw_q;
  assign cur_mode  = mode_q;
  assign seq_state = phase_code(st);
  assign evt_rec   = evt_q;
  assign trig_hw   = trig_hw_q;

endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
  parameter int N_DOM  = 9,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_DOM-1:0]  dom_req,
  input logic [1:0]        seq_state,
  input logic              seq_done,
  input logic              sw_fail,
  input logic              hw_fail,
  input logic [N_DOM-1:0]  cur_mode,
  input logic [STEP_W-1:0] cur_rank
);

  a_r11_req_only_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_req != '0) |-> (seq_state == 2'd2));

  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_done, sw_fail, hw_fail}));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  a_r8_mode_moves_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != 2'd2) |=> $stable(cur_mode));

  a_r4_rank_never_back: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_state == 2'd1 || seq_state == 2'd2) &&
     ($past(seq_state) == 2'd1 || $past(seq_state) == 2'd2))
    |-> (cur_rank >= $past(cur_rank)));

  a_r4_no_new_req_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd2) |=> ((dom_req & ~$past(dom_req)) == '0));

  a_r10_busy_ends_through_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd1 || seq_state == 2'd2) |=> (seq_state != 2'd0));

endmodule

bind pd_cascade_seq pds_checker #(.N_DOM(N_DOM), .STEP_W(STEP_W)) u_pds_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dom_req  (dom_req),
  .seq_state(seq_state),
  .seq_done (seq_done),
  .sw_fail  (sw_fail),
  .hw_fail  (hw_fail),
  .cur_mode (cur_mode),
  .cur_rank (cur_rank)
);

// File: tb/tb_pd_cascade_seq.sv
module tb_pd_cascade_seq;
  localparam int N = 9;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  sw_kick = 0, hw_evt = 0, hw_evt_en = 0;
  logic [N-1:0] sw_on_mode = 0, sw_off_mode = 0, hw_on_mode = 0, dom_ack = 0;
  logic [N*5-1:0] on_rank = 0, off_rank = 0;
  logic [15:0] tmo_thd = 16'hFFFF;
  logic [N-1:0] dom_req, cur_mode;
  logic        dom_on, seq_done, sw_fail, hw_fail, trig_hw;
  logic [1:0]  seq_state;
  logic [7:0]  evt_rec;

  pd_cascade_seq dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int dly[N];
  int cnt[N];
  int rise[N];
  logic [N-1:0] prev_req = 0;

  // expected-model outputs
  logic [N-1:0] exp_mode, exp_req;
  int exp_kind; // 0 done, 1 fail
  int got_kind; // 0 done, 1 sw fail, 2 hw fail, 3 none

  always @(posedge clk) cyc++;

  // responder: ack exactly dly[i] negedges after request is first seen
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (dom_req[i]) begin
        cnt[i]++;
        dom_ack[i] = (cnt[i] == dly[i]);
        if (!prev_req[i] && rise[i] < 0) rise[i] = cyc;
      end else begin
        cnt[i] = 0;
        dom_ack[i] = 1'b0;
      end
    end
    prev_req = dom_req;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: run hung (actual timeout, expected finish)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rk(input logic on, input int i);
    return on ? int'(on_rank[i*5 +: 5]) : int'(off_rank[i*5 +: 5]);
  endfunction

  // arithmetic model of one sequence
  task automatic model(input logic on, input logic [N-1:0] tgt, input logic [N-1:0] start,
                       input int thd);
    exp_mode = start; exp_req = 0; exp_kind = 0;
    for (int r = 0; r < 8; r++) begin
      bit any_late = 0;
      for (int i = 0; i < N; i++)
        if (tgt[i] && start[i] != on && rk(on, i) == r) begin
          exp_req[i] = 1;
          if (dly[i] <= thd + 1) exp_mode[i] = on;
          else any_late = 1;
        end
      if (any_late) begin exp_kind = 1; break; end
    end
  endtask

  task automatic clear_rec();
    for (int i = 0; i < N; i++) rise[i] = -1;
  endtask

  task automatic wait_outcome();
    got_kind = 3;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (seq_done) begin got_kind = 0; break; end
      if (sw_fail)  begin got_kind = 1; break; end
      if (hw_fail)  begin got_kind = 2; break; end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic kick(input logic [7:0] code);
    @(negedge clk); sw_kick = code;
    @(negedge clk); sw_kick = 8'h00;
  endtask

  task automatic check_seq(input string tag, input bit hwt);
    int want;
    want = (exp_kind == 0) ? 0 : (hwt ? 2 : 1);
    chk(got_kind == want, {tag, " R7 R9 outcome"}, got_kind, want);
    chk(cur_mode == exp_mode, {tag, " R8 R9 mode"}, cur_mode, exp_mode);
    for (int i = 0; i < N; i++)
      chk((rise[i] >= 0) == exp_req[i], {tag, " R5 R6 request set"}, rise[i] >= 0, exp_req[i]);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (exp_req[i] && exp_req[j] && rise[i] >= 0 && rise[j] >= 0 &&
            rk(dom_on, i) < rk(dom_on, j))
          chk(rise[i] < rise[j], {tag, " R4 rank order"}, rise[i], rise[j]);
        else if (exp_req[i] && exp_req[j] && rk(dom_on, i) == rk(dom_on, j))
          chk(rise[i] == rise[j], {tag, " R4 same rank together"}, rise[i], rise[j]);
  endtask

  function automatic int unsigned xs(input int unsigned s);
    int unsigned v = s;
    v ^= v << 13; v ^= v >> 17; v ^= v << 5;
    return v;
  endfunction

  initial begin
    int unsigned seed = 32'h1234_5678;
    logic [N-1:0] m0;
    for (int i = 0; i < N; i++) begin dly[i] = 1; cnt[i] = 0; end
    clear_rec();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cur_mode == 9'b000000011, "R1 reset mode", cur_mode, 9'b000000011);
    chk(seq_state == 2'd0, "R1 reset phase", seq_state, 0);
    chk(dom_req == 0 && !seq_done && !sw_fail && !hw_fail, "R1 reset outputs", dom_req, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 invalid code ignored
    clear_rec(); m0 = cur_mode; sw_on_mode = '1;
    kick(8'h55);
    repeat (10) @(negedge clk);
    chk(seq_state == 0 && cur_mode == m0, "R2 bad code ignored", cur_mode, m0);
    chk(rise[2] < 0, "R2 bad code no request", rise[2], -1);

    // R3 disabled event ignored
    hw_on_mode = '1; hw_evt_en = 8'h00;
    @(negedge clk); hw_evt = 8'h10; @(negedge clk); hw_evt = 0;
    repeat (10) @(negedge clk);
    chk(seq_state == 0 && cur_mode == m0, "R3 disabled event ignored", cur_mode, m0);

    // R3 enabled hardware start: ranks i%4, mask excludes domain 8
    for (int i = 0; i < N; i++) begin
      on_rank[i*5 +: 5] = 5'(i % 4); off_rank[i*5 +: 5] = 5'(3 - i % 4); dly[i] = 1 + i % 3;
    end
    on_rank[7*5 +: 5] = 5'd9; // R5 invalid rank
    hw_on_mode = 9'h0FF; hw_evt_en = 8'h08;
    model(1'b1, hw_on_mode, cur_mode, 16'hFFFF);
    clear_rec();
    @(negedge clk); hw_evt = 8'h28; @(negedge clk); hw_evt = 0;
    wait_outcome();
    check_seq("hwon", 1);
    chk(trig_hw == 1, "R3 R11 trig_hw set", trig_hw, 1);
    chk(evt_rec == 8'h08, "R3 R11 evt_rec enabled bits only", evt_rec, 8'h08);
    chk(cur_mode[7] == 0, "R5 invalid rank untouched", cur_mode[7], 0);

    // R6 skip: re-run same hardware target, nothing to do
    model(1'b1, hw_on_mode, cur_mode, 16'hFFFF);
    clear_rec();
    @(negedge clk); hw_evt = 8'h08; @(negedge clk); hw_evt = 0;
    wait_outcome();
    chk(got_kind == 0, "R6 skip done", got_kind, 0);
    chk(rise[0] < 0 && rise[3] < 0, "R6 already on no request", rise[0], -1);

    // R2 software off; R10 second trigger during run ignored
    sw_off_mode = 9'h0F3;
    for (int i = 0; i < N; i++) dly[i] = 4;
    model(1'b0, sw_off_mode, cur_mode, 16'hFFFF);
    clear_rec();
    kick(8'h50);
    @(negedge clk); sw_kick = 8'hA0; hw_evt = 8'h08; @(negedge clk); sw_kick = 0; hw_evt = 0;
    wait_outcome();
    check_seq("swoff", 0);
    chk(trig_hw == 0 && evt_rec == 0, "R2 R11 sw start clears records", {trig_hw, evt_rec}, 0);
    m0 = cur_mode; clear_rec();
    repeat (12) @(negedge clk);
    chk(seq_state == 0 && cur_mode == m0, "R10 busy trigger had no effect", cur_mode, m0);

    // R3 same-cycle hw and sw: hw wins
    hw_on_mode = 9'h004; hw_evt_en = 8'h01; dly[2] = 1;
    model(1'b1, hw_on_mode, cur_mode, 16'hFFFF);
    clear_rec();
    @(negedge clk); hw_evt = 8'h01; sw_kick = 8'h50;
    @(negedge clk); hw_evt = 0; sw_kick = 0;
    chk(seq_state == 2'd1, "R11 step phase code", seq_state, 1);
    wait_outcome();
    check_seq("both", 1);
    chk(trig_hw == 1 && evt_rec == 8'h01, "R3 hw wins same cycle", {trig_hw, evt_rec}, 9'h101);

    // R7 deadline boundary: thd=2, delay 3 passes, delay 4 fails
    tmo_thd = 16'd2;
    sw_off_mode = 9'h004; off_rank[2*5 +: 5] = 0; dly[2] = 3;
    model(1'b0, sw_off_mode, cur_mode, 2);
    clear_rec(); kick(8'h50); wait_outcome();
    check_seq("edge_ok", 0);
    sw_on_mode = 9'h004; on_rank[2*5 +: 5] = 0; dly[2] = 4;
    model(1'b1, sw_on_mode, cur_mode, 2);
    clear_rec(); kick(8'hA0); wait_outcome();
    check_seq("edge_late", 0);
    chk(dom_req == 0, "R7 requests dropped after fail", dom_req, 0);

    // R7 R8 hardware failure partial ack
    hw_on_mode = 9'h007; hw_evt_en = 8'h02;
    on_rank[0 +: 5] = 0; on_rank[5 +: 5] = 0; on_rank[10 +: 5] = 1;
    dly[0] = 1; dly[1] = 9; dly[2] = 1;
    model(1'b1, hw_on_mode, cur_mode, 2);
    clear_rec();
    @(negedge clk); hw_evt = 8'h02; @(negedge clk); hw_evt = 0;
    wait_outcome();
    check_seq("hwfail", 1);

    // sweep
    for (int it = 0; it < 40; it++) begin
      logic on;
      int thd;
      on = it[0];
      thd = (it % 4 == 3) ? 1 : 16'hFFFF;
      tmo_thd = 16'(thd);
      for (int i = 0; i < N; i++) begin
        seed = xs(seed); on_rank[i*5 +: 5] = 5'(seed % 11);
        seed = xs(seed); off_rank[i*5 +: 5] = 5'(seed % 11);
        seed = xs(seed); dly[i] = 1 + int'(seed % 4);
      end
      seed = xs(seed); sw_on_mode = 9'(seed);
      seed = xs(seed); sw_off_mode = 9'(seed);
      model(on, on ? sw_on_mode : sw_off_mode, cur_mode, thd);
      clear_rec();
      kick(on ? 8'hA0 : 8'h50);
      wait_outcome();
      check_seq("sweep", 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule